// File: doc/BRIEF.md
# Masked BCD Calendar Alarm Comparator

This block watches a running calendar (BCD seconds, minutes, hours with an AM/PM bit, a day value, and a sub-second counter) and compares it with a programmed alarm. When they match, it raises a sticky alarm flag. Each of the four coarse fields can be made a don't-care with its own mask bit. The day field can be compared either with the date or with the weekday. The sub-second comparison covers only a programmable number of low-order bits. The calendar itself is kept elsewhere and arrives on input ports.

The flag is set only on the first cycle of a match. If the match holds for many cycles, clearing the flag does not bring it back. An interrupt request is the flag gated by an enable. A write-allowed flag tells software when the alarm word may be rewritten safely.

Top module: `cal_alarm_cmp`

## Requirements
- R1: Seconds are alarm bits [6:0] (units [3:0], tens [6:4]), compared with `cal_sec_i`. Alarm bit 7 set to 1 removes seconds from the comparison.
- R2: Minutes are alarm bits [14:8], compared with `cal_min_i`. Alarm bit 15 set to 1 removes minutes from the comparison.
- R3: Hours are alarm bits [21:16] together with the AM/PM bit 22, compared with `{cal_pm_i, cal_hour_i}`. Alarm bit 23 set to 1 removes hours and AM/PM from the comparison.
- R4: The day field is alarm bits [29:24]. When bit 30 is 0, all six bits are compared with `cal_date_i`. When bit 30 is 1, bits [27:24] are compared with `{1'b0, cal_wday_i}` and bits [29:28] are ignored. Alarm bit 31 set to 1 removes the day from the comparison.
- R5: Only sub-second bits 0 through `ss_mask_cnt_i`-1 of `cal_ss_i` are compared with `ss_alarm_i`. A count of 0 ignores the sub-seconds. Bit 15 of `cal_ss_i` is never compared.
- R6: With `alarm_en_i` high, the flag sets on the clock edge at which all fields first match, so it is visible from that cycle on. It stays set until it is cleared. A match that continues does not set it again.
- R7: `alarm_clr_i` high at an edge clears the flag. If a new match begins at the same edge, the flag is set instead.
- R8: `irq_o` is high exactly when both `alarm_flag_o` and `irq_en_i` are high.
- R9: `wr_ok_o` is registered. It goes high one edge after `alarm_en_i` and `init_mode_i` are both low, and it goes low one edge after either of them is high.
- R10: While reset is held, `alarm_flag_o`, `wr_ok_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_mode_i | input | 1 | Calendar initialization mode |
| alarm_en_i | input | 1 | Alarm enable |
| irq_en_i | input | 1 | Interrupt enable |
| alarm_clr_i | input | 1 | Flag clear strobe |
| alarm_word_i | input | 32 | Packed alarm time, day and mask bits |
| ss_alarm_i | input | 15 | Sub-second alarm value |
| ss_mask_cnt_i | input | 4 | Number of low sub-second bits compared |
| cal_sec_i | input | 7 | Calendar seconds, BCD |
| cal_min_i | input | 7 | Calendar minutes, BCD |
| cal_hour_i | input | 6 | Calendar hours, BCD |
| cal_pm_i | input | 1 | Calendar AM/PM bit |
| cal_date_i | input | 6 | Calendar date, BCD |
| cal_wday_i | input | 3 | Calendar weekday |
| cal_ss_i | input | 16 | Calendar sub-second counter |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| wr_ok_o | output | 1 | Alarm word may be written |
| irq_o | output | 1 | Interrupt request |

## Verification
The flag-clear strobe and the rising edge of a new match can arrive at the same clock edge. The bench provokes this with the flag already set and the fields already equal. It holds the enable low for one cycle, then raises the enable and the clear strobe together. The flag must stay set through that edge. It must drop only at a later clear that comes with no fresh match.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned FIELD_W = 7;
  localparam int unsigned DAY_W   = 6;
  localparam int unsigned WDAY_W  = 3;
  localparam int unsigned SS_W    = 16;
  localparam int unsigned SS_CW   = $clog2(SS_W);
  localparam int unsigned N_TIME  = 3;

  typedef struct packed {
    logic             day_msk;
    logic             wd_sel;
    logic [DAY_W-1:0] day;
    logic             hr_msk;
    logic             pm;
    logic [5:0]       hour;
    logic             min_msk;
    logic [6:0]       min;
    logic             sec_msk;
    logic [6:0]       sec;
  } alarm_word_t;
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] cur_i,
  input  logic         msk_i,
  output logic         hit_o
);
  assign hit_o = msk_i | (ref_i == cur_i);
endmodule

// File: rtl/alm_day_cmp.sv
module alm_day_cmp #(
  parameter int unsigned DW  = 6,
  parameter int unsigned WDW = 3
) (
  input  logic [DW-1:0]  ref_i,
  input  logic           wd_sel_i,
  input  logic           msk_i,
  input  logic [DW-1:0]  date_i,
  input  logic [WDW-1:0] wday_i,
  output logic           hit_o
);
  localparam int unsigned UW = 4;
  logic date_eq, wday_eq;
  assign date_eq = (ref_i == date_i);
  assign wday_eq = (ref_i[UW-1:0] == UW'(wday_i));
  assign hit_o   = msk_i | (wd_sel_i ? wday_eq : date_eq);
endmodule

// File: rtl/alm_ss_cmp.sv
module alm_ss_cmp #(
  parameter int unsigned SSW = 16,
  parameter int unsigned CW  = $clog2(SSW)
) (
  input  logic [SSW-2:0] ref_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic [SSW-1:0] cur_i,
  output logic           hit_o
);
  logic [SSW-2:0] bit_ok;
  // overflow bit SSW-1 is deliberately absent
  for (genvar i = 0; i < SSW - 1; i++) begin : g_bit
    assign bit_ok[i] = (i >= int'(cnt_i)) | (ref_i[i] == cur_i[i]);
  end
  assign hit_o = &bit_ok;
endmodule

// File: rtl/alm_flag_ctl.sv
module alm_flag_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  input  logic init_mode_i,
  input  logic alarm_en_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic wr_ok_o,
  output logic irq_o
);
  logic hit_q, flag_q, wr_ok_q;
  logic hit_rise;

  assign hit_rise = hit_i & ~hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      flag_q  <= 1'b0;
      wr_ok_q <= 1'b0;
    end else begin
      hit_q <= hit_i;
      if (hit_rise)   flag_q <= 1'b1;  // new event beats clear
      else if (clr_i) flag_q <= 1'b0;
      wr_ok_q <= ~init_mode_i & ~alarm_en_i;
    end
  end

  assign flag_o  = flag_q;
  assign wr_ok_o = wr_ok_q;
  assign irq_o   = flag_q & irq_en_i;
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_mode_i,
  input  logic              alarm_en_i,
  input  logic              irq_en_i,
  input  logic              alarm_clr_i,
  input  logic [31:0]       alarm_word_i,
  input  logic [SS_W-2:0]   ss_alarm_i,
  input  logic [SS_CW-1:0]  ss_mask_cnt_i,
  input  logic [6:0]        cal_sec_i,
  input  logic [6:0]        cal_min_i,
  input  logic [5:0]        cal_hour_i,
  input  logic              cal_pm_i,
  input  logic [DAY_W-1:0]  cal_date_i,
  input  logic [WDAY_W-1:0] cal_wday_i,
  input  logic [SS_W-1:0]   cal_ss_i,
  output logic              alarm_flag_o,
  output logic              wr_ok_o,
  output logic              irq_o
);
  alarm_word_t aw;
  assign aw = alarm_word_t'(alarm_word_i);

  logic [FIELD_W-1:0] f_ref [N_TIME];
  logic [FIELD_W-1:0] f_cur [N_TIME];
  logic [N_TIME-1:0]  f_msk;
  logic [N_TIME-1:0]  f_hit;
  logic day_hit, ss_hit_w, hit_w;

  assign f_ref[0] = aw.sec;
  assign f_ref[1] = aw.min;
  assign f_ref[2] = {aw.pm, aw.hour};
  assign f_cur[0] = cal_sec_i;
  assign f_cur[1] = cal_min_i;
  assign f_cur[2] = {cal_pm_i, cal_hour_i};
  assign f_msk    = {aw.hr_msk, aw.min_msk, aw.sec_msk};

  for (genvar k = 0; k < N_TIME; k++) begin : g_time
    alm_field_cmp #(.W(FIELD_W)) u_cmp (
      .ref_i (f_ref[k]),
      .cur_i (f_cur[k]),
      .msk_i (f_msk[k]),
      .hit_o (f_hit[k])
    );
  end

  alm_day_cmp #(.DW(DAY_W), .WDW(WDAY_W)) u_day (
    .ref_i    (aw.day),
    .wd_sel_i (aw.wd_sel),
    .msk_i    (aw.day_msk),
    .date_i   (cal_date_i),
    .wday_i   (cal_wday_i),
    .hit_o    (day_hit)
  );

  alm_ss_cmp #(.SSW(SS_W), .CW(SS_CW)) u_ss (
    .ref_i (ss_alarm_i),
    .cnt_i (ss_mask_cnt_i),
    .cur_i (cal_ss_i),
    .hit_o (ss_hit_w)
  );

  assign hit_w = alarm_en_i & (&f_hit) & day_hit & ss_hit_w;

  alm_flag_ctl u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit_w),
    .clr_i       (alarm_clr_i),
    .init_mode_i (init_mode_i),
    .alarm_en_i  (alarm_en_i),
    .irq_en_i    (irq_en_i),
    .flag_o      (alarm_flag_o),
    .wr_ok_o     (wr_ok_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_mode_i,
  input logic              alarm_en_i,
  input logic              irq_en_i,
  input logic              alarm_clr_i,
  input logic [3:0]        ss_mask_cnt_i,
  input logic              hit_w,
  input logic              ss_hit_w,
  input logic              alarm_flag_o,
  input logic              wr_ok_o,
  input logic              irq_o
);
  logic hit_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit_w;
  end

  p_rise_needs_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_flag_o) |-> $past(hit_w));
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_flag_o && !alarm_clr_i) |=> alarm_flag_o);
  p_new_hit_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_w && !hit_q) |=> alarm_flag_o);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_clr_i && !(hit_w && !hit_q)) |=> !alarm_flag_o);
  p_irq_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (alarm_flag_o && irq_en_i));
  p_wr_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_mode_i || alarm_en_i) |=> !wr_ok_o);
  p_wr_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_mode_i && !alarm_en_i) |=> wr_ok_o);
  p_ss_cnt0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_mask_cnt_i == 4'd0) |-> ss_hit_w);
endmodule

bind cal_alarm_cmp cal_alarm_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .init_mode_i   (init_mode_i),
  .alarm_en_i    (alarm_en_i),
  .irq_en_i      (irq_en_i),
  .alarm_clr_i   (alarm_clr_i),
  .ss_mask_cnt_i (ss_mask_cnt_i),
  .hit_w         (hit_w),
  .ss_hit_w      (ss_hit_w),
  .alarm_flag_o  (alarm_flag_o),
  .wr_ok_o       (wr_ok_o),
  .irq_o         (irq_o)
);

// File: tb/sim_cal_alarm_cmp.sv
`timescale 1ns/1ps
module sim_cal_alarm_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_mode = 1'b0, alarm_en = 1'b0, irq_en = 1'b0, alarm_clr = 1'b0;
  logic [31:0] aw = '0;
  logic [14:0] ss_alarm = '0;
  logic [3:0]  ss_cnt = '0;
  logic [6:0]  sec = '0, mnt = '0;
  logic [5:0]  hour = '0;
  logic        pm = 1'b0;
  logic [5:0]  date = '0;
  logic [2:0]  wday = '0;
  logic [15:0] ss = '0;
  logic        flag, wr_ok, irq;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cal_alarm_cmp u0 (
    .clk_i(clk), .rst_ni(rst_n), .init_mode_i(init_mode), .alarm_en_i(alarm_en),
    .irq_en_i(irq_en), .alarm_clr_i(alarm_clr), .alarm_word_i(aw),
    .ss_alarm_i(ss_alarm), .ss_mask_cnt_i(ss_cnt), .cal_sec_i(sec),
    .cal_min_i(mnt), .cal_hour_i(hour), .cal_pm_i(pm), .cal_date_i(date),
    .cal_wday_i(wday), .cal_ss_i(ss), .alarm_flag_o(flag), .wr_ok_o(wr_ok),
    .irq_o(irq)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic model();
    logic ok = 1'b1;
    ok &= aw[7]  | (aw[6:0] == sec);
    ok &= aw[15] | (aw[14:8] == mnt);
    ok &= aw[23] | (aw[22:16] == {pm, hour});
    ok &= aw[31] | (aw[30] ? (aw[27:24] == {1'b0, wday}) : (aw[29:24] == date));
    for (int b = 0; b < 15; b++)
      if (b < int'(ss_cnt) && ss_alarm[b] != ss[b]) ok = 1'b0;
    return ok;
  endfunction

  // all fields equal, nothing masked
  task automatic base();
    sec = 7'h25; mnt = 7'h41; hour = 6'h11; pm = 1'b1; date = 6'h28; wday = 3'd5;
    ss = 16'h1234; ss_alarm = 15'h1234; ss_cnt = 4'd15;
    aw = {1'b0, 1'b0, 6'h28, 1'b0, 1'b1, 6'h11, 1'b0, 7'h41, 1'b0, 7'h25};
  endtask

  // fields already set; clear, re-arm, check flag after the arming edge
  task automatic vec(input string tag);
    @(negedge clk); alarm_en = 1'b0; alarm_clr = 1'b1;
    @(negedge clk); alarm_clr = 1'b0; alarm_en = 1'b1;
    @(negedge clk);
    check(tag, flag, model());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    base();
    repeat (3) @(negedge clk);
    check("R10 flag in reset", flag, 1'b0);
    check("R10 wr_ok in reset", wr_ok, 1'b0);
    check("R10 irq in reset", irq, 1'b0);
    rst_n = 1'b1;

    // R1 seconds: raw sweep with and without mask
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 128; v++) begin
        base(); aw[7] = m[0]; sec = v[6:0]; vec("R1 seconds");
      end
    // R2 minutes
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 128; v++) begin
        base(); aw[15] = m[0]; mnt = v[6:0]; vec("R2 minutes");
      end
    // R3 hours with AM/PM
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 128; v++) begin
        base(); aw[23] = m[0]; {pm, hour} = v[6:0]; vec("R3 hours");
      end
    // R4 day: date vs weekday, masked and not
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int v = 0; v < 64; v++) begin
          base(); aw[31] = m[0]; aw[30] = s[0];
          if (s == 1) begin aw[29:24] = {v[1:0], 4'd3}; wday = v[4:2]; end
          else date = v[5:0];
          vec("R4 day");
        end
    // R5 sub-second compare width
    for (int c = 0; c < 16; c++)
      for (int b = 0; b < 16; b++) begin
        base(); ss_cnt = c[3:0]; ss = 16'h1234 ^ (16'h1 << b); vec("R5 subsec");
      end

    // R6 sustained match does not re-trigger after clear
    base(); vec("R6 arm");
    check("R6 flag set", flag, 1'b1);
    @(negedge clk); alarm_clr = 1'b1;
    @(negedge clk); alarm_clr = 1'b0;
    repeat (4) begin
      @(negedge clk); check("R6 no retrigger", flag, 1'b0);
    end

    // R7 clear and fresh match at the same edge
    base(); vec("R7 arm");
    @(negedge clk); alarm_en = 1'b0;
    @(negedge clk); check("R7 flag held", flag, 1'b1);
    alarm_en = 1'b1; alarm_clr = 1'b1;
    @(negedge clk); check("R7 set beats clear", flag, 1'b1);
    @(negedge clk); check("R7 plain clear", flag, 1'b0);
    alarm_clr = 1'b0;

    // R8 interrupt gating
    base(); vec("R8 arm");
    irq_en = 1'b0; #1 check("R8 irq disabled", irq, 1'b0);
    irq_en = 1'b1; #1 check("R8 irq enabled", irq, 1'b1);
    @(negedge clk); alarm_clr = 1'b1;
    @(negedge clk); alarm_clr = 1'b0; check("R8 irq after clear", irq, 1'b0);
    irq_en = 1'b0;

    // R9 write-allowed flag
    check("R9 enabled blocks", wr_ok, 1'b0);
    alarm_en = 1'b0;
    check("R9 not yet", wr_ok, 1'b0);
    @(negedge clk); check("R9 opens", wr_ok, 1'b1);
    init_mode = 1'b1;
    @(negedge clk); check("R9 init blocks", wr_ok, 1'b0);
    init_mode = 1'b0;
    @(negedge clk); check("R9 reopens", wr_ok, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule